// File: doc/BRIEF.md
# Time-Slotted ADC Input Sequencer

This block shares one delta-sigma converter among several analog inputs by cycling through a programmable number of time slots. Each slot has two 4-bit select registers: a regular one and an alternate one. When the slot opens, the block drives the value of one of them onto the analog multiplexer and pulses a conversion start. A frame is one full cycle of slots. An alternate-frame request is sampled when a frame begins, and the alternate registers are then used for every slot of that frame.

Slot timing is counted in whole periods of a slow reference clock. The block samples that clock and detects its rising edges in the fast system clock domain. A filter-length code sets how many slow periods each slot lasts. The same code, together with a clock-mode bit, sets how many result bits are valid. When a slot ends, the block issues one write to an external result RAM:

- The address is the signal number that was selected for the slot.
- The data is the converter result masked to the valid resolution, LSB-justified, then shifted left by eight bits.

A select code of all ones marks an empty slot. An empty slot still takes its time but produces no write.

Top module: `adc_slot_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `conv_start_o`, `wr_en_o`, `mux_sel_o`, `slot_o`, `wr_addr_o` and `wr_data_o` are all zero.
- R2: With `enable_i` low and no frame running, the block issues no conversion start and no write. The first slow-clock rising edge seen with `enable_i` high starts a frame at slot 0.
- R3: A slot lasts `flen_i`+1 slow-clock periods for codes 0, 1 and 2. Code 3 behaves as code 2. `conv_start_o` pulses for one fast cycle, in the cycle after the slow rising edge that opens the slot.
- R4: A frame visits slots 0, 1, … N-1 in ascending order, where N is `slots_i` clamped to the range 1..10 (0 gives 1, values above 10 give 10). `slot_o` shows the open slot.
- R5: `mux_sel_o` takes the slot's field from `sel_regular_i` (bits 4k+3:4k for slot k). If `alt_req_i` was high on the edge that opened slot 0, it takes the field from `sel_alternate_i` instead, for the whole frame.
- R6: On the slow rising edge that closes a slot, `wr_en_o` pulses for one fast cycle with `wr_addr_o` equal to that slot's select code. This is the same cycle as the next slot's start pulse.
- R7: `wr_data_o` = (`conv_result_i` sampled on the closing edge, keeping only its low B bits) shifted left by 8. With `hires_i`=0, B is 18, 21 or 22 for filter code 0, 1 or 2. With `hires_i`=1, B is 19, 22 or 24. Code 3 uses the code-2 value.
- R8: A select code of 4'hF gives no write, but the slot still lasts its full length.
- R9: Values of `slots_i`, `flen_i` and `hires_i` are captured only when a frame starts. Changes made during a frame take effect at the next frame.
- R10: Between slow rising edges, `conv_start_o` and `wr_en_o` stay low.
- R11: If `enable_i` is low when the last slot of a frame closes, that slot's write still occurs and the block then idles with no further start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Allows frames to start or continue |
| slow_clk_i | input | 1 | Slow reference clock, sampled by `clk` |
| slots_i | input | 4 | Number of active slots per frame |
| flen_i | input | 2 | Filter-length code (sets slot length and resolution) |
| hires_i | input | 1 | Clock-mode bit that selects the higher resolution table |
| alt_req_i | input | 1 | Requests alternate selects for the next frame |
| sel_regular_i | input | 40 | Ten regular 4-bit select codes, slot k at bits 4k+3:4k |
| sel_alternate_i | input | 40 | Ten alternate 4-bit select codes, same layout |
| conv_result_i | input | 24 | Filtered converter result |
| conv_start_o | output | 1 | Conversion start pulse |
| mux_sel_o | output | 4 | Analog multiplexer select code |
| slot_o | output | 4 | Index of the open slot |
| wr_en_o | output | 1 | Result RAM write enable |
| wr_addr_o | output | 4 | Result RAM address (signal number) |
| wr_data_o | output | 32 | Result RAM write data |

## Verification
The hardest case to reach from the ports is a configuration change made mid-frame, where the old slot count and filter length must keep governing the slots still to run. A near case is the final slot closing with `enable_i` already low. The bench changes `slots_i`, `flen_i`, `hires_i` and `alt_req_i` during the slow-clock low phase, both partway through a directed frame and at random points in a long random run. Its reference model latches configuration only at frame starts, so every later start pulse, select code and write is checked against the old values. Empty codes, out-of-range slot counts and filter code 3 are forced directly and also occur in the random fields.

// File: rtl/sqr_pkg.sv
package sqr_pkg;

  // Valid result bits for a filter-length code and clock mode.
  function automatic int unsigned res_bits(input logic [1:0] flen, input logic hires);
    logic [1:0] f;
    f = (flen == 2'd3) ? 2'd2 : flen;
    if (hires) begin
      case (f)
        2'd0:    return 19;
        2'd1:    return 22;
        default: return 24;
      endcase
    end else begin
      case (f)
        2'd0:    return 18;
        2'd1:    return 21;
        default: return 22;
      endcase
    end
  endfunction

endpackage

// File: rtl/sqr_edge.sv
module sqr_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/sqr_frame.sv
module sqr_frame #(
  parameter int NSLOT = 10,
  parameter int SELW  = 4,
  localparam int CNTW = $clog2(NSLOT + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick_i,
  input  logic                   enable_i,
  input  logic [CNTW-1:0]        slots_i,
  input  logic [1:0]             flen_i,
  input  logic                   hires_i,
  input  logic                   alt_req_i,
  input  logic [NSLOT*SELW-1:0]  sel_regular_i,
  input  logic [NSLOT*SELW-1:0]  sel_alternate_i,
  output logic                   start_o,
  output logic [SELW-1:0]        sel_o,
  output logic [CNTW-1:0]        slot_o,
  output logic                   slot_end_o,
  output logic [1:0]             flen_o,
  output logic                   hires_o
);
  logic            run_q, alt_q, hires_q;
  logic [CNTW-1:0] slot_q, n_q, slot_nxt, n_new;
  logic [1:0]      cnt_q, len_q, flen_q;
  logic            slot_end, last, begin_frame, next_slot;
  logic [SELW-1:0] reg_a [NSLOT];
  logic [SELW-1:0] alt_a [NSLOT];

  for (genvar k = 0; k < NSLOT; k++) begin : g_unpack
    assign reg_a[k] = sel_regular_i[k*SELW +: SELW];
    assign alt_a[k] = sel_alternate_i[k*SELW +: SELW];
  end

  always_comb begin
    if (slots_i == '0)                     n_new = CNTW'(1);
    else if (slots_i > CNTW'(NSLOT))       n_new = CNTW'(NSLOT);
    else                                   n_new = slots_i;
  end

  assign slot_nxt    = slot_q + 1'b1;
  assign slot_end    = tick_i & run_q & (cnt_q == len_q);
  assign last        = (slot_nxt == n_q);
  assign begin_frame = tick_i & enable_i & (~run_q | (slot_end & last));
  assign next_slot   = slot_end & ~last;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      alt_q   <= 1'b0;
      hires_q <= 1'b0;
      slot_q  <= '0;
      n_q     <= CNTW'(1);
      cnt_q   <= '0;
      len_q   <= '0;
      flen_q  <= '0;
      start_o <= 1'b0;
      sel_o   <= '0;
    end else begin
      start_o <= begin_frame | next_slot;
      if (begin_frame) begin
        run_q   <= 1'b1;
        slot_q  <= '0;
        cnt_q   <= '0;
        n_q     <= n_new;
        len_q   <= (flen_i == 2'd3) ? 2'd2 : flen_i;
        flen_q  <= flen_i;
        hires_q <= hires_i;
        alt_q   <= alt_req_i;
        sel_o   <= alt_req_i ? alt_a[0] : reg_a[0];
      end else if (next_slot) begin
        slot_q <= slot_nxt;
        cnt_q  <= '0;
        sel_o  <= alt_q ? alt_a[slot_nxt] : reg_a[slot_nxt];
      end else if (slot_end) begin
        run_q <= 1'b0;
      end else if (tick_i & run_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign slot_o     = slot_q;
  assign slot_end_o = slot_end;
  assign flen_o     = flen_q;
  assign hires_o    = hires_q;
endmodule

// File: rtl/sqr_store.sv
module sqr_store #(
  parameter int SELW  = 4,
  parameter int RESW  = 24,
  parameter int SHIFT = 8,
  localparam int DW   = RESW + SHIFT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slot_end_i,
  input  logic [SELW-1:0] sel_i,
  input  logic [1:0]      flen_i,
  input  logic            hires_i,
  input  logic [RESW-1:0] result_i,
  output logic            wr_en_o,
  output logic [SELW-1:0] wr_addr_o,
  output logic [DW-1:0]   wr_data_o
);
  import sqr_pkg::*;

  int unsigned     nbits;
  logic [RESW-1:0] keep;
  logic            empty;

  assign empty = &sel_i;

  always_comb begin
    nbits = res_bits(flen_i, hires_i);
    if (nbits > RESW) nbits = RESW;
    for (int i = 0; i < RESW; i++) keep[i] = (i < int'(nbits));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= slot_end_i & ~empty;
      if (slot_end_i & ~empty) begin
        wr_addr_o <= sel_i;
        wr_data_o <= {result_i & keep, {SHIFT{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/adc_slot_seq.sv
module adc_slot_seq #(
  parameter int NSLOT = 10,
  parameter int SELW  = 4,
  parameter int RESW  = 24,
  parameter int SHIFT = 8,
  localparam int CNTW = $clog2(NSLOT + 1),
  localparam int DW   = RESW + SHIFT
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable_i,
  input  logic                  slow_clk_i,
  input  logic [CNTW-1:0]       slots_i,
  input  logic [1:0]            flen_i,
  input  logic                  hires_i,
  input  logic                  alt_req_i,
  input  logic [NSLOT*SELW-1:0] sel_regular_i,
  input  logic [NSLOT*SELW-1:0] sel_alternate_i,
  input  logic [RESW-1:0]       conv_result_i,
  output logic                  conv_start_o,
  output logic [SELW-1:0]       mux_sel_o,
  output logic [CNTW-1:0]       slot_o,
  output logic                  wr_en_o,
  output logic [SELW-1:0]       wr_addr_o,
  output logic [DW-1:0]         wr_data_o
);
  logic       tick, slot_end, hires_act;
  logic [1:0] flen_act;

  sqr_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (slow_clk_i),
    .rise_o (tick)
  );

  sqr_frame #(.NSLOT(NSLOT), .SELW(SELW)) u_frame (
    .clk             (clk),
    .rst             (rst),
    .tick_i          (tick),
    .enable_i        (enable_i),
    .slots_i         (slots_i),
    .flen_i          (flen_i),
    .hires_i         (hires_i),
    .alt_req_i       (alt_req_i),
    .sel_regular_i   (sel_regular_i),
    .sel_alternate_i (sel_alternate_i),
    .start_o         (conv_start_o),
    .sel_o           (mux_sel_o),
    .slot_o          (slot_o),
    .slot_end_o      (slot_end),
    .flen_o          (flen_act),
    .hires_o         (hires_act)
  );

  sqr_store #(.SELW(SELW), .RESW(RESW), .SHIFT(SHIFT)) u_store (
    .clk        (clk),
    .rst        (rst),
    .slot_end_i (slot_end),
    .sel_i      (mux_sel_o),
    .flen_i     (flen_act),
    .hires_i    (hires_act),
    .result_i   (conv_result_i),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );
endmodule

// File: rtl/adc_slot_seq_chk.sv
module adc_slot_seq_chk #(
  parameter int NSLOT = 10,
  parameter int SELW  = 4,
  parameter int SHIFT = 8,
  parameter int CNTW  = 4,
  parameter int DW    = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            slow_clk_i,
  input logic            conv_start_o,
  input logic            wr_en_o,
  input logic [SELW-1:0] wr_addr_o,
  input logic [DW-1:0]   wr_data_o,
  input logic [CNTW-1:0] slot_o
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst) conv_start_o |=> !conv_start_o); // R3
  AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (rst) conv_start_o |-> $past(slow_clk_i)); // R10
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst) wr_en_o |=> !wr_en_o); // R6
  AST_WR_ON_EDGE: assert property (@(posedge clk) disable iff (rst) wr_en_o |-> $past(slow_clk_i)); // R10
  AST_WR_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst) wr_en_o |-> (wr_addr_o != {SELW{1'b1}})); // R8
  AST_DATA_ALIGNED: assert property (@(posedge clk) disable iff (rst) wr_en_o |-> (wr_data_o[SHIFT-1:0] == '0)); // R7
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst) slot_o < CNTW'(NSLOT)); // R4
endmodule

bind adc_slot_seq adc_slot_seq_chk #(
  .NSLOT(NSLOT), .SELW(SELW), .SHIFT(SHIFT), .CNTW(CNTW), .DW(DW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .slow_clk_i   (slow_clk_i),
  .conv_start_o (conv_start_o),
  .wr_en_o      (wr_en_o),
  .wr_addr_o    (wr_addr_o),
  .wr_data_o    (wr_data_o),
  .slot_o       (slot_o)
);

// File: tb/tb_adc_slot_seq.sv
module tb_adc_slot_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 10;
  localparam int SELW  = 4;
  localparam int RESW  = 24;
  localparam int DW    = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic en = 1'b0, slow = 1'b0, hires = 1'b0, alt_req = 1'b0;
  logic [3:0] slots = 4'd7;
  logic [1:0] flen = 2'd0;
  logic [NSLOT*SELW-1:0] regv = '0, altv = '0;
  logic [RESW-1:0] res = '0;
  logic conv_start, wr_en;
  logic [3:0] mux_sel, slot, wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0, fails = 0;
  string phase = "R2";

  // reference model state
  bit m_run = 0, m_alt = 0, m_hires = 0;
  int m_slot = 0, m_cnt = 0, m_n = 1, m_len = 0, m_flen = 0;
  logic [3:0] m_cur = 0;
  bit e_start, e_wr;
  logic [3:0] e_sel, e_addr;
  int e_slot;
  logic [DW-1:0] e_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_slot_seq dut (
    .clk(clk), .rst(rst), .enable_i(en), .slow_clk_i(slow), .slots_i(slots),
    .flen_i(flen), .hires_i(hires), .alt_req_i(alt_req), .sel_regular_i(regv),
    .sel_alternate_i(altv), .conv_result_i(res), .conv_start_o(conv_start),
    .mux_sel_o(mux_sel), .slot_o(slot), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, phase, $time, act, exp);
    end
  endtask

  function automatic int resb(int f, bit h);
    int g = (f > 2) ? 2 : f;
    if (h) return (g == 0) ? 19 : (g == 1) ? 22 : 24;
    return (g == 0) ? 18 : (g == 1) ? 21 : 22;
  endfunction

  function automatic logic [DW-1:0] fmt(logic [RESW-1:0] r, int f, bit h);
    logic [DW-1:0] d = '0;
    int b = resb(f, h);
    for (int i = 0; i < b; i++) d[i+8] = r[i];
    return d;
  endfunction

  task automatic start_slot();
    e_start = 1;
    m_cur = m_alt ? altv[m_slot*4 +: 4] : regv[m_slot*4 +: 4];
    e_sel = m_cur;
    e_slot = m_slot;
  endtask

  task automatic begin_frame();
    m_run = 1; m_slot = 0; m_cnt = 0;
    m_n = (slots == 0) ? 1 : (slots > NSLOT) ? NSLOT : int'(slots);
    m_flen = int'(flen); m_len = (flen == 3) ? 2 : int'(flen);
    m_hires = hires; m_alt = alt_req;
    start_slot();
  endtask

  task automatic model_step();
    e_start = 0; e_wr = 0;
    if (!m_run) begin
      if (en) begin_frame();
    end else if (m_cnt == m_len) begin
      if (m_cur != 4'hF) begin
        e_wr = 1; e_addr = m_cur; e_data = fmt(res, m_flen, m_hires);
      end
      if (m_slot == m_n - 1) begin
        if (en) begin_frame(); else m_run = 0;
      end else begin
        m_slot++; m_cnt = 0; start_slot();
      end
    end else m_cnt++;
  endtask

  // one slow-clock period: rising edge, checks, then low phase
  task automatic slow_cycle(int hi, int lo);
    @(negedge clk); slow = 1'b1; model_step();
    @(negedge clk);
    chk("R3", conv_start, e_start);
    chk("R6", wr_en, e_wr);
    if (e_start) begin
      chk("R5", mux_sel, e_sel);
      chk("R4", slot, e_slot);
    end
    if (e_wr) begin
      chk("R6", wr_addr, e_addr);
      chk("R7", wr_data, e_data);
    end
    for (int i = 1; i < hi; i++) begin
      @(negedge clk); chk("R10", {conv_start, wr_en}, 0);
    end
    @(negedge clk); slow = 1'b0;
    for (int i = 0; i < lo; i++) begin
      @(negedge clk); chk("R10", {conv_start, wr_en}, 0);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) slow_cycle(1 + $urandom % 3, 1 + $urandom % 3);
  endtask

  task automatic rand_sels();
    for (int k = 0; k < NSLOT; k++) begin
      regv[k*4 +: 4] = 4'($urandom % 16);
      altv[k*4 +: 4] = 4'($urandom % 16);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < NSLOT; k++) begin
      regv[k*4 +: 4] = 4'(k);
      altv[k*4 +: 4] = 4'(9 - k);
    end
    repeat (3) @(negedge clk);
    // R1: reset state, during and right after reset
    chk("R1", {conv_start, wr_en, mux_sel, slot, wr_addr}, 0);
    chk("R1", wr_data, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {conv_start, wr_en, mux_sel, slot, wr_addr}, 0);

    phase = "R2"; run(4);                       // idle, nothing issued
    en = 1'b1; slots = 4'd7; flen = 2'd0;
    phase = "R4"; res = 24'hFFFFFF; run(15);
    phase = "R3"; flen = 2'd1; run(20);
    flen = 2'd3; hires = 1'b1; run(24);         // code 3 acts as code 2
    phase = "R5"; alt_req = 1'b1; run(12); alt_req = 1'b0; run(10);
    phase = "R9"; slots = 4'd7; flen = 2'd0; run(10);
    slots = 4'd3; flen = 2'd2; hires = 1'b0; run(3);   // mid-frame change
    run(20);
    phase = "R4"; slots = 4'd0; run(4); slots = 4'd15; flen = 2'd0; run(24);
    phase = "R8"; regv[3*4 +: 4] = 4'hF; regv[5*4 +: 4] = 4'hF; slots = 4'd6; run(14);
    phase = "R11"; run(3); en = 1'b0; run(12);
    phase = "R2"; en = 1'b1; run(5);
    phase = "R7";
    for (int j = 0; j < 500; j++) begin
      res = 24'($urandom);
      if ($urandom % 6 == 0) rand_sels();
      if ($urandom % 8 == 0) slots = 4'($urandom % 16);
      if ($urandom % 8 == 0) flen = 2'($urandom % 4);
      if ($urandom % 8 == 0) hires = 1'($urandom % 2);
      if ($urandom % 4 == 0) alt_req = 1'($urandom % 2);
      if ($urandom % 40 == 0) en = ~en;
      slow_cycle(1 + $urandom % 3, 1 + $urandom % 3);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule